// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block holds a shared 64-bit real-time counter and one 64-bit compare value for each hart, all on a small memory-mapped register port. The counter advances by one on every clock in which the external tick-enable input is high. Software may read it or overwrite it at any time. Each hart gets a level timer-interrupt line. The line is high whenever that hart's compare value is at or below the live counter.

The register port carries an address, a write enable, 64-bit write data, 64-bit read data and an access-size bit. The size bit selects a 4-byte or an 8-byte access. Read data is combinational from the address and size. A 4-byte write updates one half of a 64-bit register and keeps the other half, so a 32-bit host can program the counter and the compare values one word at a time. The compare registers sit in 8-byte slots starting at a configurable base. The counter sits at its own configurable base. Every line is compared against the live counter, so a rewrite of the counter can raise or drop all interrupt lines together.

Top module: `hart_timer_cmp`

## Requirements
- R1: While `tick_en` is high and no counter write occurs, the counter increases by exactly one per clock and wraps from all ones to zero; with `tick_en` low it holds.
- R2: The counter's bits 31:0 are at `TIME_BASE` and its bits 63:32 at `TIME_BASE+4`. An 8-byte access at `TIME_BASE` reads or writes all 64 bits.
- R3: The compare value of hart n occupies the 8-byte slot at `CMP_BASE+8*n`, with its low word at byte offset 0 and high word at byte offset 4. `timer_irq[n]` is high exactly when the unsigned compare value is less than or equal to the counter. It reflects the registers one clock edge after they change, so writing a compare value in the past raises the line on the next edge.
- R4: Writing a compare value above the counter drops that hart's line on the following edge. The line then stays low until the counter reaches that value.
- R5: `bus_size`=0 selects a 4-byte access and `bus_size`=1 selects an 8-byte access. A 4-byte write takes `bus_wdata[31:0]` into the addressed half and keeps the other half. A 4-byte read, and any read at offset 4, returns the addressed word in bits 31:0 with bits 63:32 zero. This holds for the counter and the compare registers alike.
- R6: An 8-byte write at offset 4 of the counter or of a compare slot changes no register.
- R7: Reads of an unmapped address return zero, and writes to one change no register. Unmapped addresses are those with address bits 1:0 nonzero, those outside the counter and compare slots, and compare slots for hart indices at or above `NUM_HARTS`.
- R8: After reset the counter is zero, every compare value is all ones and every interrupt line is low.
- R9: A counter write in the same cycle as a tick loads exactly the written value; the tick is lost.
- R10: A counter rewrite re-evaluates every hart together, so on the next edge all lines whose compare value is at or below the new counter rise and all others fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the counter by one this cycle |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 1 | 0: 4-byte access, 1: 8-byte access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for the current address and size |
| timer_irq | output | NUM_HARTS | Level timer interrupt, one per hart |

## Verification
Read data is due in the same cycle as the address, so the bench applies it after a falling edge and samples a nanosecond later with no clock edge between. A write or tick lands in the registers on the next rising edge. Any interrupt line that depends on it is due one rising edge after that. The bench's model therefore computes each cycle's expected interrupts from its state before it applies that cycle's write. It compares them at the falling edge after the rising edge, so a directed check of a raised or dropped line is taken two edges after the write.

// File: rtl/htc_pkg.sv
package htc_pkg;
   localparam int unsigned TIME_W = 64;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned SLOT_BYTES = 8;
   localparam int unsigned MAX_HARTS = 8;

   typedef enum logic {
      ACC_WORD  = 1'b0,
      ACC_DWORD = 1'b1
   } acc_size_e;

   // new value of a 64-bit register after a write of the given size and half
   function automatic logic [TIME_W-1:0] merge_write(
      input logic [TIME_W-1:0] old_val,
      input logic [TIME_W-1:0] wdata,
      input logic              dword,
      input logic              hi_half
   );
      logic [TIME_W-1:0] res;
      if (dword) begin
         res = wdata;
      end else if (hi_half) begin
         res = {wdata[WORD_W-1:0], old_val[WORD_W-1:0]};
      end else begin
         res = {old_val[TIME_W-1:WORD_W], wdata[WORD_W-1:0]};
      end
      return res;
   endfunction

   // shape a register's value for the read port
   function automatic logic [TIME_W-1:0] read_shape(
      input logic [TIME_W-1:0] val,
      input logic              dword,
      input logic              hi_half
   );
      logic [TIME_W-1:0] res;
      if (hi_half) begin
         res = {{WORD_W{1'b0}}, val[TIME_W-1:WORD_W]};
      end else if (!dword) begin
         res = {{WORD_W{1'b0}}, val[WORD_W-1:0]};
      end else begin
         res = val;
      end
      return res;
   endfunction
endpackage

// File: rtl/htc_decode.sv
module htc_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned CMP_BASE  = 0,
   parameter int unsigned TIME_BASE = 16'h7FF8
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 dword,
   output logic                 time_sel,
   output logic [NUM_HARTS-1:0] cmp_sel,
   output logic                 hi_half,
   output logic                 write_legal
);
   localparam logic [ADDR_W-1:0] TIME_ADDR = ADDR_W'(TIME_BASE);

   logic aligned;

   assign aligned     = (addr[1:0] == 2'b00);
   assign hi_half     = addr[2];
   // 8-byte writes are only meaningful at the start of a slot
   assign write_legal = !(dword && addr[2]);
   assign time_sel    = aligned && (addr[ADDR_W-1:3] == TIME_ADDR[ADDR_W-1:3]);

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(CMP_BASE + htc_pkg::SLOT_BYTES * h);
      assign cmp_sel[h] = aligned && (addr[ADDR_W-1:3] == SLOT_ADDR[ADDR_W-1:3]);
   end
endmodule

// File: rtl/htc_counter.sv
module htc_counter
   import htc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              dword,
   input  logic              hi_half,
   input  logic [TIME_W-1:0] wdata,
   output logic [TIME_W-1:0] time_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
      end else if (wr_en) begin
         time_q <= merge_write(time_q, wdata, dword, hi_half);
      end else if (tick_en) begin
         time_q <= time_q + TIME_W'(1);
      end
   end
endmodule

// File: rtl/htc_cmp_bank.sv
module htc_cmp_bank
   import htc_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_HARTS-1:0]        wr_sel,
   input  logic                        dword,
   input  logic                        hi_half,
   input  logic [TIME_W-1:0]           wdata,
   input  logic [TIME_W-1:0]           time_q,
   output logic [NUM_HARTS*TIME_W-1:0] cmp_flat,
   output logic [NUM_HARTS-1:0]        irq_q
);
   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic [TIME_W-1:0] cmp_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_q <= '1;
         end else if (wr_sel[h]) begin
            cmp_q <= merge_write(cmp_q, wdata, dword, hi_half);
         end
      end

      // registered level compare against the live counter
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_q[h] <= 1'b0;
         end else begin
            irq_q[h] <= (cmp_q <= time_q);
         end
      end

      assign cmp_flat[h*TIME_W +: TIME_W] = cmp_q;
   end
endmodule

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp
   import htc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned CMP_BASE  = 16'h0000,
   parameter int unsigned TIME_BASE = 16'h7FF8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_size,
   input  logic [63:0]          bus_wdata,
   output logic [63:0]          bus_rdata,
   output logic [NUM_HARTS-1:0] timer_irq
);
   localparam int unsigned CMP_END = CMP_BASE + SLOT_BYTES * NUM_HARTS;

   // elaboration-time parameter checks
   if (NUM_HARTS < 1 || NUM_HARTS > MAX_HARTS) begin : g_bad_harts
      $error("hart_timer_cmp: NUM_HARTS must be 1..8");
   end
   if ((CMP_BASE % SLOT_BYTES) != 0 || (TIME_BASE % SLOT_BYTES) != 0) begin : g_bad_align
      $error("hart_timer_cmp: bases must be 8-byte aligned");
   end
   if (TIME_BASE + SLOT_BYTES > CMP_BASE && TIME_BASE < CMP_END) begin : g_bad_overlap
      $error("hart_timer_cmp: counter overlaps compare slots");
   end
   if (ADDR_W < 4 || ADDR_W > 31 || CMP_END > (1 << ADDR_W) || TIME_BASE >= (1 << ADDR_W)) begin : g_bad_width
      $error("hart_timer_cmp: register map does not fit ADDR_W");
   end

   logic                        time_sel;
   logic [NUM_HARTS-1:0]        cmp_sel;
   logic                        hi_half;
   logic                        write_legal;
   logic                        time_wr;
   logic [NUM_HARTS-1:0]        cmp_wr;
   logic [TIME_W-1:0]           time_q;
   logic [NUM_HARTS*TIME_W-1:0] cmp_flat;
   logic [TIME_W-1:0]           rd_val;

   htc_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_HARTS (NUM_HARTS),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE)
   ) u_decode (
      .addr        (bus_addr),
      .dword       (bus_size),
      .time_sel    (time_sel),
      .cmp_sel     (cmp_sel),
      .hi_half     (hi_half),
      .write_legal (write_legal)
   );

   assign time_wr = bus_we && write_legal && time_sel;
   assign cmp_wr  = (bus_we && write_legal) ? cmp_sel : '0;

   htc_counter u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (time_wr),
      .dword   (bus_size),
      .hi_half (hi_half),
      .wdata   (bus_wdata),
      .time_q  (time_q)
   );

   htc_cmp_bank #(
      .NUM_HARTS (NUM_HARTS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (cmp_wr),
      .dword    (bus_size),
      .hi_half  (hi_half),
      .wdata    (bus_wdata),
      .time_q   (time_q),
      .cmp_flat (cmp_flat),
      .irq_q    (timer_irq)
   );

   always_comb begin
      rd_val = '0;
      if (time_sel) begin
         rd_val = time_q;
      end
      for (int h = 0; h < NUM_HARTS; h++) begin
         if (cmp_sel[h]) begin
            rd_val = cmp_flat[h*TIME_W +: TIME_W];
         end
      end
   end

   assign bus_rdata = (time_sel || (|cmp_sel)) ? read_shape(rd_val, bus_size, hi_half) : '0;
endmodule

// File: rtl/htc_checker.sv
module htc_checker #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned CMP_BASE  = 0,
   parameter int unsigned TIME_BASE = 16'h7FF8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tick_en,
   input logic                    bus_we,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic                    bus_size,
   input logic [63:0]             bus_wdata,
   input logic [63:0]             time_q,
   input logic [NUM_HARTS*64-1:0] cmp_flat,
   input logic [NUM_HARTS-1:0]    timer_irq
);
   localparam logic [ADDR_W-1:0] T_LO = ADDR_W'(TIME_BASE);
   localparam logic [ADDR_W-1:0] T_HI = ADDR_W'(TIME_BASE + 4);
   localparam int unsigned CMP_END = CMP_BASE + 8 * NUM_HARTS;

   logic mapped;
   always_comb begin
      mapped = 1'b0;
      if (bus_addr[1:0] == 2'b00) begin
         if (bus_addr == T_LO || bus_addr == T_HI) begin
            mapped = 1'b1;
         end
         if (32'(bus_addr) >= CMP_BASE && 32'(bus_addr) < CMP_END) begin
            mapped = 1'b1;
         end
      end
   end

   a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !bus_we) |=> (time_q == $past(time_q) + 64'd1));

   a_r9_write_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_size && bus_addr == T_LO) |=> (time_q == $past(bus_wdata)));

   a_r5_low_write_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_size && bus_addr == T_LO && !tick_en)
      |=> (time_q[63:32] == $past(time_q[63:32])));

   a_r6_wide_hi_time_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_size && bus_addr == T_HI && !tick_en) |=> $stable(time_q));

   a_r6_wide_hi_cmp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_size && bus_addr[2]) |=> $stable(cmp_flat));

   a_r7_unmapped_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !mapped) |=> $stable(cmp_flat));

   a_r7_unmapped_time: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !mapped && !tick_en) |=> $stable(time_q));

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
      // R3 / R10: each line is the registered unsigned compare
      a_r3_level_compare: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (timer_irq[h] == $past(cmp_flat[h*64 +: 64] <= time_q)));
   end
endmodule

bind hart_timer_cmp htc_checker #(
   .ADDR_W    (ADDR_W),
   .NUM_HARTS (NUM_HARTS),
   .CMP_BASE  (CMP_BASE),
   .TIME_BASE (TIME_BASE)
) u_htc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_size  (bus_size),
   .bus_wdata (bus_wdata),
   .time_q    (time_q),
   .cmp_flat  (cmp_flat),
   .timer_irq (timer_irq)
);

// File: tb/hart_timer_cmp_bench.sv
module hart_timer_cmp_bench;
   localparam int unsigned AW = 16;
   localparam int unsigned NH = 4;
   localparam int unsigned CB = 16'h0100;
   localparam int unsigned TB = 16'h0040;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_size = 1'b0;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic [NH-1:0] timer_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0]   time_m;
   logic [63:0]   cmp_m [NH];
   logic [NH-1:0] irq_m;

   always #5 clk = ~clk;

   hart_timer_cmp #(
      .ADDR_W (AW), .NUM_HARTS (NH), .CMP_BASE (CB), .TIME_BASE (TB)
   ) u_hart_timer_cmp (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .bus_we (bus_we),
      .bus_addr (bus_addr), .bus_size (bus_size), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .timer_irq (timer_irq)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // which model register an address names: -2 unmapped, -1 counter, else hart
   function automatic int reg_of(input logic [AW-1:0] a);
      int base;
      if (a[1:0] != 2'b00) return -2;
      base = int'({a[AW-1:3], 3'b000});
      if (base == int'(TB)) return -1;
      if (base >= int'(CB) && base < int'(CB + 8 * NH)) return (base - int'(CB)) / 8;
      return -2;
   endfunction

   function automatic logic [63:0] model_read(input logic [AW-1:0] a, input logic sz);
      int r;
      logic [63:0] v;
      r = reg_of(a);
      if (r == -2) return 64'd0;
      v = (r == -1) ? time_m : cmp_m[r];
      if (a[2]) return {32'd0, v[63:32]};
      if (!sz) return {32'd0, v[31:0]};
      return v;
   endfunction

   function automatic logic [63:0] model_merge(input logic [63:0] old, input logic [63:0] w,
                                               input logic sz, input logic hi);
      if (sz) return w;
      if (hi) return {w[31:0], old[31:0]};
      return {old[63:32], w[31:0]};
   endfunction

   // one clock: drive, model the edge, check interrupts at the falling edge
   task automatic step(input logic we, input logic [AW-1:0] a, input logic sz,
                       input logic [63:0] wd, input logic tk);
      int r;
      bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd; tick_en = tk;
      @(posedge clk);
      for (int h = 0; h < NH; h++) irq_m[h] = (cmp_m[h] <= time_m);
      r = reg_of(a);
      if (we && !(sz && a[2]) && r == -1) begin
         time_m = model_merge(time_m, wd, sz, a[2]);
      end else begin
         if (tk) time_m = time_m + 64'd1;
         if (we && !(sz && a[2]) && r >= 0) cmp_m[r] = model_merge(cmp_m[r], wd, sz, a[2]);
      end
      @(negedge clk);
      bus_we = 1'b0; tick_en = 1'b0;
      chk(timer_irq === irq_m, "R3 irq level", 64'(timer_irq), 64'(irq_m));
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic sz, input string req);
      bus_we = 1'b0; tick_en = 1'b0; bus_addr = a; bus_size = sz;
      #1;
      chk(bus_rdata === model_read(a, sz), req, bus_rdata, model_read(a, sz));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 1'b0);
   endtask

   function automatic logic [AW-1:0] pick_addr();
      int unsigned k;
      k = $urandom % 8;
      if (k < 4) return AW'(CB + ($urandom % (NH + 2)) * 8 + ($urandom % 2) * 4);
      if (k < 6) return AW'(TB + ($urandom % 2) * 4);
      if (k == 6) return AW'($urandom);
      return AW'(TB + 1 + ($urandom % 3));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a;
      logic [63:0]   w;
      void'($urandom(32'd20240611));
      time_m = '0; irq_m = '0;
      for (int h = 0; h < NH; h++) cmp_m[h] = '1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state
      chk(timer_irq === '0, "R8 irq after reset", 64'(timer_irq), 64'd0);
      rd(AW'(TB), 1'b1, "R8 counter reset");
      chk(bus_rdata === 64'd0, "R8 counter zero", bus_rdata, 64'd0);
      rd(AW'(CB + 8), 1'b1, "R8 compare reset");
      chk(bus_rdata === '1, "R8 compare ones", bus_rdata, '1);
      idle(3);

      // R2 counter map
      step(1'b1, AW'(TB), 1'b1, 64'h0000_0001_FFFF_FFF0, 1'b0);
      rd(AW'(TB), 1'b1, "R2 full read");
      rd(AW'(TB + 4), 1'b0, "R2 high word");
      chk(bus_rdata === 64'd1, "R2 high word value", bus_rdata, 64'd1);
      rd(AW'(TB), 1'b0, "R2 low word");
      chk(bus_rdata === 64'hFFFF_FFF0, "R2 low word value", bus_rdata, 64'hFFFF_FFF0);

      // R1 ticking across a word boundary, then wrap
      for (int i = 0; i < 20; i++) step(1'b0, '0, 1'b0, '0, 1'b1);
      rd(AW'(TB), 1'b1, "R1 after ticks");
      chk(bus_rdata === 64'h0000_0002_0000_0004, "R1 tick count", bus_rdata, 64'h0000_0002_0000_0004);
      step(1'b1, AW'(TB), 1'b1, '1, 1'b0);
      step(1'b0, '0, 1'b0, '0, 1'b1);
      rd(AW'(TB), 1'b1, "R1 wrap");
      chk(bus_rdata === 64'd0, "R1 wrap to zero", bus_rdata, 64'd0);

      // R5 half writes merge
      step(1'b1, AW'(TB), 1'b1, 64'h1111_2222_3333_4444, 1'b0);
      step(1'b1, AW'(TB), 1'b0, 64'hDEAD_0000_AAAA_BBBB, 1'b0);
      rd(AW'(TB), 1'b1, "R5 low merge");
      chk(bus_rdata === 64'h1111_2222_AAAA_BBBB, "R5 time low merge", bus_rdata, 64'h1111_2222_AAAA_BBBB);
      step(1'b1, AW'(TB + 4), 1'b0, 64'hBEEF_0000_5555_6666, 1'b0);
      rd(AW'(TB), 1'b1, "R5 high merge");
      chk(bus_rdata === 64'h5555_6666_AAAA_BBBB, "R5 time high merge", bus_rdata, 64'h5555_6666_AAAA_BBBB);
      step(1'b1, AW'(CB + 8), 1'b0, 64'h0000_0000_1234_5678, 1'b0);
      rd(AW'(CB + 8), 1'b1, "R5 compare merge");
      chk(bus_rdata === 64'hFFFF_FFFF_1234_5678, "R5 compare low merge", bus_rdata, 64'hFFFF_FFFF_1234_5678);

      // R6 wide write at offset 4 ignored
      step(1'b1, AW'(TB + 4), 1'b1, 64'h0, 1'b0);
      rd(AW'(TB), 1'b1, "R6 time unchanged");
      chk(bus_rdata === 64'h5555_6666_AAAA_BBBB, "R6 time kept", bus_rdata, 64'h5555_6666_AAAA_BBBB);
      step(1'b1, AW'(CB + 8 + 4), 1'b1, 64'h0, 1'b0);
      rd(AW'(CB + 8), 1'b1, "R6 compare kept");

      // R7 unmapped
      rd(AW'(CB + 8 * NH), 1'b1, "R7 unmapped hart read");
      chk(bus_rdata === 64'd0, "R7 unmapped hart zero", bus_rdata, 64'd0);
      rd(AW'(TB + 2), 1'b0, "R7 misaligned read");
      chk(bus_rdata === 64'd0, "R7 misaligned zero", bus_rdata, 64'd0);
      step(1'b1, AW'(CB + 8 * NH), 1'b1, 64'd0, 1'b0);
      step(1'b1, AW'(TB + 1), 1'b1, 64'd0, 1'b0);
      for (int h = 0; h < NH; h++) rd(AW'(CB + 8 * h), 1'b1, "R7 compares untouched");
      rd(AW'(TB), 1'b1, "R7 counter untouched");

      // R3 / R4 past and future compare values
      step(1'b1, AW'(TB), 1'b1, 64'd1000, 1'b0);
      step(1'b1, AW'(CB), 1'b1, 64'd500, 1'b0);
      step(1'b0, '0, 1'b0, '0, 1'b0);
      chk(timer_irq[0] === 1'b1, "R3 past compare raises", 64'(timer_irq[0]), 64'd1);
      step(1'b1, AW'(CB), 1'b1, 64'd1005, 1'b0);
      step(1'b0, '0, 1'b0, '0, 1'b0);
      chk(timer_irq[0] === 1'b0, "R4 future compare drops", 64'(timer_irq[0]), 64'd0);
      for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, '0, 1'b1);
      step(1'b0, '0, 1'b0, '0, 1'b0);
      chk(timer_irq[0] === 1'b0, "R4 still below", 64'(timer_irq[0]), 64'd0);
      step(1'b0, '0, 1'b0, '0, 1'b1);
      step(1'b0, '0, 1'b0, '0, 1'b0);
      chk(timer_irq[0] === 1'b1, "R4 reached", 64'(timer_irq[0]), 64'd1);

      // R10 counter rewrite moves every line together
      for (int h = 0; h < NH; h++) step(1'b1, AW'(CB + 8 * h), 1'b1, 64'd2000, 1'b0);
      step(1'b1, AW'(TB), 1'b1, 64'd1500, 1'b0);
      step(1'b0, '0, 1'b0, '0, 1'b0);
      chk(timer_irq === '0, "R10 all low", 64'(timer_irq), 64'd0);
      step(1'b1, AW'(TB), 1'b1, 64'd2000, 1'b0);
      step(1'b0, '0, 1'b0, '0, 1'b0);
      chk(timer_irq === '1, "R10 all high", 64'(timer_irq), 64'(NH'('1)));

      // R9 write beats tick
      step(1'b1, AW'(TB), 1'b1, 64'h0000_00AB_0000_0010, 1'b1);
      rd(AW'(TB), 1'b1, "R9 write wins");
      chk(bus_rdata === 64'h0000_00AB_0000_0010, "R9 exact value", bus_rdata, 64'h0000_00AB_0000_0010);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         a = pick_addr();
         case ($urandom % 3)
            0: w = time_m + 64'($urandom % 64) - 64'd32;
            1: w = {$urandom, $urandom};
            default: w = {32'd0, $urandom};
         endcase
         step(($urandom % 3) != 0, a, $urandom % 2, w, ($urandom % 2) == 1);
         if (i % 4 == 0) rd(pick_addr(), $urandom % 2, "R5 random read");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule